// File: doc/BRIEF.md
# Single-operand negate, clear and complement unit

This unit carries out the four one-operand data operations of an integer core: negate with extend, clear, negate and bitwise complement. It works on byte, word or long operands. The core gives it the instruction word, the operand that has already been fetched, the current extend (X) and zero (Z) flags, and a bit that says whether the destination is in memory. One clock later the unit returns the result, the new N, Z, V, C and X flags, and the number of bus cycles the instruction takes. The result keeps the operand bits above the selected size, so it can be written straight back to a register.

Operand fetch and result store belong to the core. The unit also checks the instruction word. A reserved size code or an address-register destination is not one of these instructions, and the unit raises an illegal indication for it.

Top module: `negclr_unit`

## Requirements
- R1: Instruction word fields: bits 10:9 pick the operation (0 negate-with-extend, 1 clear, 2 negate, 3 complement). Bits 7:6 pick the size (0 byte, 1 word, 2 long). Bits 5:3 give the destination addressing mode.
- R2: A size code of 3, or a destination mode of 001 (address register), sets `illegal`. In that case the result equals the operand, Z and X are passed through unchanged, N, V and C are 0, and the cycle count is 0.
- R3: Clear writes zero into the sized field and produces N=0, Z=1, V=0, C=0. X is left unchanged.
- R4: Complement inverts the sized field. N is the sign bit of the sized result, Z is set when the sized result is zero, V and C are cleared, and X is left unchanged.
- R5: Negate computes 0 minus the operand at the selected width. N and Z come from the result. C is set when the sized operand is nonzero. V is set when the sign bits of the sized operand and of the sized result are both 1. X equals the new C.
- R6: Negate-with-extend computes 0 minus the operand minus X at the selected width. C is set when the sized operand is nonzero or X is 1. V follows the rule of R5, and X equals the new C. Z is cleared when the sized result is nonzero; otherwise Z keeps its input value.
- R7: Result bits above the selected size are copied from the operand. Those bits never affect N, Z, V or C.
- R8: The cycle count is 4 for byte and word and 6 for long. It is doubled when `mem_dst` is 1.
- R9: All outputs are registered with a latency of one clock. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_word | input | 16 | Instruction word |
| operand | input | 32 | Fetched operand value |
| x_in | input | 1 | Current extend flag |
| z_in | input | 1 | Current zero flag |
| mem_dst | input | 1 | Destination is in memory |
| result | output | 32 | Result, with the bits above the size taken from the operand |
| flag_n | output | 1 | New negative flag |
| flag_z | output | 1 | New zero flag |
| flag_v | output | 1 | New overflow flag |
| flag_c | output | 1 | New carry/borrow flag |
| flag_x | output | 1 | New extend flag |
| cycles | output | 4 | Bus cycle count |
| illegal | output | 1 | Instruction word is not a valid encoding of these operations |

## Verification
The bench sweeps every combination of operation, size code, destination mode (data register, address register, memory), destination flag, X and Z. Each combination is run against eight operand values:
- Zero and a zero sized field with nonzero upper bits tell the sticky Z of the extend form apart from the ordinary Z.
- One and all-ones check borrow and sign.
- The most negative and the most positive value of each size separate the overflow rule from a plain sign test.
- An irregular pattern with nonzero upper bits shows that the bits above the size are carried through and kept out of the flags.

The size code 3 and the address-register mode cover the illegal handling.

// File: rtl/negclr_pkg.sv
package negclr_pkg;

   // Operation select encoding, taken from the instruction word
   typedef enum logic [1:0] {
      OP_NEGX = 2'd0,
      OP_CLR  = 2'd1,
      OP_NEG  = 2'd2,
      OP_NOT  = 2'd3
   } una_op_e;

   // Positions of the fields in the instruction word
   localparam int OPW_BITS     = 16;
   localparam int OPSEL_LSB    = 9;
   localparam int SIZE_LSB     = 6;
   localparam int EAMODE_LSB   = 3;

   localparam logic [1:0] SZ_RESERVED = 2'd3;
   localparam logic [2:0] EA_ADDR_REG = 3'b001;

endpackage

// File: rtl/negclr_lane.sv
// One width lane: computes the sized result and the sized flags for every operation.
module negclr_lane
   import negclr_pkg::*;
#(
   parameter int W = 8
) (
   input  una_op_e        op_sel,
   input  logic [W-1:0]   src,
   input  logic           x_in,
   output logic [W-1:0]   res,
   output logic           n_o,
   output logic           zero_o,
   output logic           v_o,
   output logic           c_o
);

   generate
      if (W < 2) begin : g_bad_w
         $error("negclr_lane: W must be at least 2");
      end
   endgenerate

   logic         use_x;
   logic [W:0]   diff;

   assign use_x = (op_sel == OP_NEGX) ? x_in : 1'b0;
   assign diff  = {1'b0, {W{1'b0}}} - {1'b0, src} - {{W{1'b0}}, use_x};

   always_comb begin
      res = '0;
      v_o = 1'b0;
      c_o = 1'b0;
      unique case (op_sel)
         OP_NEGX, OP_NEG: begin
            res = diff[W-1:0];
            c_o = diff[W];
            v_o = src[W-1] & diff[W-1];
         end
         OP_CLR: res = '0;
         OP_NOT: res = ~src;
         default: res = '0;
      endcase
   end

   assign n_o    = res[W-1];
   assign zero_o = (res == '0);

endmodule

// File: rtl/negclr_cycles.sv
// Cycle count from size and destination kind.
module negclr_cycles #(
   parameter int CYC_W     = 4,
   parameter int CYC_SHORT = 4,
   parameter int CYC_LONG  = 6
) (
   input  logic [1:0]       sz,
   input  logic             mem_dst,
   output logic [CYC_W-1:0] cyc
);

   generate
      if ((CYC_LONG * 2) >= (1 << CYC_W)) begin : g_bad_cyc
         $error("negclr_cycles: CYC_W too narrow for doubled long count");
      end
   endgenerate

   localparam logic [CYC_W-1:0] SHORT_V = CYC_W'(CYC_SHORT);
   localparam logic [CYC_W-1:0] LONG_V  = CYC_W'(CYC_LONG);

   logic [CYC_W-1:0] base;

   assign base = (sz == 2'd2) ? LONG_V : SHORT_V;
   assign cyc  = mem_dst ? (base << 1) : base;

endmodule

// File: rtl/negclr_unit.sv
module negclr_unit
   import negclr_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CYC_W     = 4,
   parameter int CYC_SHORT = 4,
   parameter int CYC_LONG  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       op_word,
   input  logic [DATA_W-1:0] operand,
   input  logic              x_in,
   input  logic              z_in,
   input  logic              mem_dst,
   output logic [DATA_W-1:0] result,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_v,
   output logic              flag_c,
   output logic              flag_x,
   output logic [CYC_W-1:0]  cycles,
   output logic              illegal
);

   localparam int NUM_SIZES = 3;

   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("negclr_unit: DATA_W must be 32 (byte/word/long lanes)");
      end
   endgenerate

   una_op_e    op_sel;
   logic [1:0] sz;
   logic [2:0] ea_mode;
   logic       illegal_c;
   logic [1:0] sz_idx;

   assign op_sel    = una_op_e'(op_word[OPSEL_LSB +: 2]);
   assign sz        = op_word[SIZE_LSB +: 2];
   assign ea_mode   = op_word[EAMODE_LSB +: 3];
   assign illegal_c = (sz == SZ_RESERVED) || (ea_mode == EA_ADDR_REG);
   assign sz_idx    = illegal_c ? 2'd0 : sz;

   logic [DATA_W-1:0] lane_res  [NUM_SIZES];
   logic [DATA_W-1:0] lane_mask [NUM_SIZES];
   logic              lane_n    [NUM_SIZES];
   logic              lane_zero [NUM_SIZES];
   logic              lane_v    [NUM_SIZES];
   logic              lane_c    [NUM_SIZES];

   generate
      for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
         localparam int LW = 8 << g;
         logic [LW-1:0] r_g;
         negclr_lane #(.W(LW)) u_lane (
            .op_sel (op_sel),
            .src    (operand[LW-1:0]),
            .x_in   (x_in),
            .res    (r_g),
            .n_o    (lane_n[g]),
            .zero_o (lane_zero[g]),
            .v_o    (lane_v[g]),
            .c_o    (lane_c[g])
         );
         assign lane_res[g]  = DATA_W'(r_g);
         assign lane_mask[g] = ~({DATA_W{1'b1}} << LW);
      end
   endgenerate

   logic [CYC_W-1:0] cyc_c;

   negclr_cycles #(
      .CYC_W     (CYC_W),
      .CYC_SHORT (CYC_SHORT),
      .CYC_LONG  (CYC_LONG)
   ) u_cyc (
      .sz      (sz),
      .mem_dst (mem_dst),
      .cyc     (cyc_c)
   );

   logic [DATA_W-1:0] res_c;
   logic              n_c, z_c, v_c, c_c, x_c;
   logic [CYC_W-1:0]  cycles_c;

   always_comb begin
      res_c    = operand;
      n_c      = 1'b0;
      z_c      = z_in;
      v_c      = 1'b0;
      c_c      = 1'b0;
      x_c      = x_in;
      cycles_c = '0;
      if (!illegal_c) begin
         res_c    = (operand & ~lane_mask[sz_idx]) | lane_res[sz_idx];
         n_c      = lane_n[sz_idx];
         v_c      = lane_v[sz_idx];
         c_c      = lane_c[sz_idx];
         cycles_c = cyc_c;
         unique case (op_sel)
            OP_NEGX: begin
               z_c = lane_zero[sz_idx] ? z_in : 1'b0;
               x_c = lane_c[sz_idx];
            end
            OP_NEG: begin
               z_c = lane_zero[sz_idx];
               x_c = lane_c[sz_idx];
            end
            default: z_c = lane_zero[sz_idx];
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result  <= '0;
         flag_n  <= 1'b0;
         flag_z  <= 1'b0;
         flag_v  <= 1'b0;
         flag_c  <= 1'b0;
         flag_x  <= 1'b0;
         cycles  <= '0;
         illegal <= 1'b0;
      end else begin
         result  <= res_c;
         flag_n  <= n_c;
         flag_z  <= z_c;
         flag_v  <= v_c;
         flag_c  <= c_c;
         flag_x  <= x_c;
         cycles  <= cycles_c;
         illegal <= illegal_c;
      end
   end

endmodule

// File: rtl/negclr_unit_chk.sv
module negclr_unit_chk #(
   parameter int DATA_W = 32,
   parameter int CYC_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [15:0]       op_word,
   input logic [DATA_W-1:0] operand,
   input logic              x_in,
   input logic              z_in,
   input logic              mem_dst,
   input logic [DATA_W-1:0] result,
   input logic              flag_n,
   input logic              flag_z,
   input logic              flag_v,
   input logic              flag_c,
   input logic              flag_x,
   input logic [CYC_W-1:0]  cycles,
   input logic              illegal
);

   logic [1:0] c_op;
   logic [1:0] c_sz;
   logic       c_legal;

   assign c_op    = op_word[10:9];
   assign c_sz    = op_word[7:6];
   assign c_legal = (c_sz != 2'd3) && (op_word[5:3] != 3'b001);

   // R9: outputs are zero while reset is held
   p_reset_zero_r9: assert property (@(posedge clk)
      !$past(rst_n) |-> (result == '0 && cycles == '0 && !illegal));

   p_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(!c_legal) |->
         illegal && cycles == '0 && result == $past(operand) && flag_x == $past(x_in));

   p_clear_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(c_legal && c_op == 2'd1) |->
         !flag_n && flag_z && !flag_v && !flag_c && flag_x == $past(x_in));

   p_not_cv_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(c_legal && c_op == 2'd3) |->
         !flag_v && !flag_c && flag_x == $past(x_in));

   p_x_equals_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(c_legal && c_op[0] == 1'b0) |-> flag_x == flag_c);

   p_sticky_z_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(c_legal && c_op == 2'd0 && !z_in) |-> !flag_z);

   p_upper_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(c_legal && c_sz == 2'd0) |->
         result[DATA_W-1:8] == $past(operand[DATA_W-1:8]));

   p_cycle_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(c_legal) |->
         (cycles == CYC_W'(4) || cycles == CYC_W'(6) ||
          cycles == CYC_W'(8) || cycles == CYC_W'(12)));

endmodule

bind negclr_unit negclr_unit_chk #(.DATA_W(DATA_W), .CYC_W(CYC_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .op_word (op_word),
   .operand (operand),
   .x_in    (x_in),
   .z_in    (z_in),
   .mem_dst (mem_dst),
   .result  (result),
   .flag_n  (flag_n),
   .flag_z  (flag_z),
   .flag_v  (flag_v),
   .flag_c  (flag_c),
   .flag_x  (flag_x),
   .cycles  (cycles),
   .illegal (illegal)
);

// File: tb/negclr_unit_tb.sv
module negclr_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] op_word = '0;
   logic [31:0] operand = '0;
   logic        x_in = 1'b0;
   logic        z_in = 1'b0;
   logic        mem_dst = 1'b0;
   logic [31:0] result;
   logic        flag_n, flag_z, flag_v, flag_c, flag_x, illegal;
   logic [3:0]  cycles;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   negclr_unit dut_i (
      .clk(clk), .rst_n(rst_n), .op_word(op_word), .operand(operand),
      .x_in(x_in), .z_in(z_in), .mem_dst(mem_dst), .result(result),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
      .flag_x(flag_x), .cycles(cycles), .illegal(illegal)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] pick_val(input int k, input int w);
      logic [63:0] m;
      m = (64'd1 << w) - 64'd1;
      case (k)
         0: return 32'd0;
         1: return 32'd1;
         2: return 32'(64'd1 << (w - 1));
         3: return 32'(m);
         4: return 32'((64'd1 << (w - 1)) - 64'd1);
         5: return 32'hA5C3_0F96;
         6: return 32'hFFFF_FF00;
         default: return 32'h8000_0000;
      endcase
   endfunction

   task automatic run_vec(input int op, input int sz, input int ea,
                          input int mem, input int xv, input int zv,
                          input logic [31:0] val);
      int w;
      logic [63:0] m, msb, s, d;
      logic e_n, e_z, e_v, e_c, e_x, e_ill;
      logic [31:0] e_res;
      logic [3:0] e_cyc;
      string tag;
      w   = (sz == 3) ? 8 : (8 << sz);
      m   = (64'd1 << w) - 64'd1;
      msb = 64'd1 << (w - 1);
      s   = {32'd0, val} & m;
      e_ill = (sz == 3) || (ea == 1);
      e_n = 0; e_v = 0; e_c = 0; e_z = zv[0]; e_x = xv[0];
      d = 0;
      tag = "R1";
      case (op)
         0: begin
            d = (64'd0 - s - 64'(xv)) & m;
            e_c = (s != 0) || (xv != 0);
            e_v = ((s & msb) != 0) && ((d & msb) != 0);
            e_z = (d != 0) ? 1'b0 : zv[0];
            e_x = e_c; tag = "R6";
         end
         1: begin d = 0; e_z = 1; tag = "R3"; end
         2: begin
            d = (64'd0 - s) & m;
            e_c = (s != 0);
            e_v = ((s & msb) != 0) && ((d & msb) != 0);
            e_z = (d == 0); e_x = e_c; tag = "R5";
         end
         default: begin
            d = ~s & m; e_z = (d == 0); tag = "R4";
         end
      endcase
      e_n   = (d & msb) != 0;
      e_res = 32'(({32'd0, val} & ~m) | d);
      e_cyc = ((w == 32) ? 4'd6 : 4'd4) << mem;
      if (e_ill) begin
         e_res = val; e_n = 0; e_v = 0; e_c = 0; e_z = zv[0]; e_x = xv[0];
         e_cyc = 0; tag = "R2";
      end
      op_word = 16'((op << 9) | (sz << 6) | (ea << 3) | 2);
      operand = val; mem_dst = mem[0]; x_in = xv[0]; z_in = zv[0];
      @(negedge clk);
      chk(tag, "illegal", 32'(illegal), 32'(e_ill));
      chk(e_ill ? tag : "R7", "result", result, e_res);
      chk(tag, "N", 32'(flag_n), 32'(e_n));
      chk(tag, "Z", 32'(flag_z), 32'(e_z));
      chk(tag, "V", 32'(flag_v), 32'(e_v));
      chk(tag, "C", 32'(flag_c), 32'(e_c));
      chk(tag, "X", 32'(flag_x), 32'(e_x));
      chk(e_ill ? tag : "R8", "cycles", 32'(cycles), 32'(e_cyc));
   endtask

   initial begin
      op_word = 16'h0240; operand = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9", "reset result", result, 32'd0);
      chk("R9", "reset cycles", 32'(cycles), 32'd0);
      chk("R9", "reset flags", 32'({flag_n, flag_z, flag_v, flag_c, flag_x, illegal}), 32'd0);
      rst_n = 1'b1;
      for (int op = 0; op < 4; op++)
         for (int sz = 0; sz < 4; sz++)
            for (int ea = 0; ea < 3; ea++)
               for (int mem = 0; mem < 2; mem++)
                  for (int xv = 0; xv < 2; xv++)
                     for (int zv = 0; zv < 2; zv++)
                        for (int k = 0; k < 8; k++)
                           run_vec(op, sz, ea, mem, xv, zv,
                                   pick_val(k, (sz == 3) ? 8 : (8 << sz)));
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule